// File: doc/BRIEF.md
# Coalescing Outstanding Request Table

This block tracks the memory requests a processor has in flight, with one table entry for each cache line that is waiting on the memory system. A request whose line has no entry takes a free entry and goes downstream at once with its secondary kind. Later requests to the same line are appended to that line's queue, so only one downstream request per line is ever in flight. When merging is turned off, such requests are refused with an aliased status and the requester retries them.

A completion arrives with a line number and a read or write flag. The block then leaves its idle state and steps through that line's queue, handing back one completion per cycle in arrival order. Each completion carries the request's ID and primary kind, and a flag on the one request that actually went downstream. A write completion empties the queue. A read completion stops at the first write-class request and reissues it with its secondary kind. The block also keeps a line lock that locked read-modify-write completions set and clear, raises a lock-clear pulse when permission is lost on a line holding a queued store-conditional, and raises a sticky error when any queued request grows too old.

The control is a three-state machine. IDLE accepts requests and completions. DRAIN_RD and DRAIN_WR pop one queued request per cycle. The transitions are: IDLE to DRAIN_RD on a read completion for a held line, IDLE to DRAIN_WR on a write completion for a held line, DRAIN_RD to IDLE on a reissue, on an emptied queue, or after one pop with merging off, and DRAIN_WR to IDLE on an emptied queue or after one pop with merging off.

Top module: `lrt_table`

## Requirements
- R1: Addresses that differ only in the low log2(LINE_BYTES) bits belong to the same line and share one entry.
- R2: In IDLE, a request to a line with no entry, with a free entry and no completion presented, is answered in the same cycle with status 1 (issued; 0 = none, 2 = aliased, 3 = stall). In that same cycle `iss_valid` is high with the line number and the secondary kind, and `pending` rises by one after the edge.
- R3: With `merge_en` high, a request to a held line whose queue is not full is answered with status 1 and appended to the tail, with no downstream issue. `pending` rises by one.
- R4: With `merge_en` low, a request to a held line is answered with status 2, and no state changes.
- R5: A request gets status 3, and no state changes, when no entry is free, when the target queue already holds QDEPTH requests, when a completion is presented in the same cycle, or when the block is draining.
- R6: A write completion (`cmp_write` high) for a held line returns every queued request of that line, one per cycle starting in the next cycle, in arrival order, with `done_first` high only on the first. The entry is then freed.
- R7: A read completion pops requests of kind load (0) or ifetch (1). After the first pop, a head of any other kind is not popped: in that cycle `iss_valid` is high with the line and that request's secondary kind, and the request stays queued. Write-class kinds are store 2, atomic 3, RMW read 4, RMW write 5, load-linked 6, store-conditional 7, locked RMW read 8, locked RMW write 9 and flush 10.
- R8: With `merge_en` low, each completion returns exactly one request and frees the entry.
- R9: Returning a locked RMW read (kind 8) sets `blk_active` with `blk_line` set to that line after the edge. Returning a locked RMW write (kind 9) clears it.
- R10: `lock_clear` is high in a cycle exactly when `perm_lost` is high and the queue of line `perm_line` holds a store-conditional (kind 7).
- R11: `deadlock` rises one cycle after any queued request has been held THRESH cycles, and it stays high until reset.
- R12: `pending` always equals the number of queued requests over all entries, and it is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| merge_en | input | 1 | Queue requests to held lines (1) or refuse them (0) |
| req_valid | input | 1 | CPU request present |
| req_addr | input | AW | Request byte address |
| req_prim | input | 4 | Primary kind |
| req_sec | input | 4 | Secondary kind used downstream |
| req_id | input | IDW | Requester tag |
| rsp_status | output | 2 | 0 none, 1 issued, 2 aliased, 3 stall |
| iss_valid | output | 1 | Downstream request this cycle |
| iss_line | output | LW | Downstream line number |
| iss_kind | output | 4 | Downstream kind |
| cmp_valid | input | 1 | Completion from memory |
| cmp_write | input | 1 | Completion is write-class |
| cmp_line | input | LW | Completed line number |
| done_valid | output | 1 | Request returned this cycle |
| done_id | output | IDW | Returned request tag |
| done_kind | output | 4 | Returned request primary kind |
| done_first | output | 1 | Returned request was the one sent downstream |
| perm_lost | input | 1 | Line permission lost |
| perm_line | input | LW | Line that lost permission |
| lock_clear | output | 1 | Clear the lock of `perm_line` |
| blk_active | output | 1 | A line is blocked by a locked RMW |
| blk_line | output | LW | Blocked line |
| pending | output | CW | Number of queued requests |
| deadlock | output | 1 | Sticky stale-request flag |

## Verification
The bench targets a read completion that meets a queued store behind two loads. A design that popped the store would return it early and never reissue it, and one that stopped before the loads would strand them. It fills every entry, then one queue to full depth, so a design that overwrote a slot or took a fifth line would show the wrong status or lose a completion. It also presents a completion in the same cycle as a request and toggles merging. A design that queued refused requests would make `pending` drift, and one that kept the entry after a single pop with merging off would alias the next request. Lock set and clear, the store-conditional hook on a matching and a non-matching line, and the age threshold crossing are each compared cycle by cycle against the model.

// File: rtl/lrt_pkg.sv
package lrt_pkg;

    typedef enum logic [3:0] {
        K_LOAD    = 4'd0,
        K_IFETCH  = 4'd1,
        K_STORE   = 4'd2,
        K_ATOMIC  = 4'd3,
        K_RMW_RD  = 4'd4,
        K_RMW_WR  = 4'd5,
        K_LL      = 4'd6,
        K_SC      = 4'd7,
        K_LRMW_RD = 4'd8,
        K_LRMW_WR = 4'd9,
        K_FLUSH   = 4'd10
    } kind_e;

    typedef enum logic [1:0] {
        RS_NONE    = 2'd0,
        RS_ISSUED  = 2'd1,
        RS_ALIASED = 2'd2,
        RS_STALL   = 2'd3
    } status_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_DRAIN_RD = 2'd1,
        ST_DRAIN_WR = 2'd2
    } fsm_e;

    function automatic logic is_wr(input logic [3:0] k);
        return !((k == K_LOAD) || (k == K_IFETCH));
    endfunction

endpackage

// File: rtl/lrt_line_match.sv
module lrt_line_match #(
    parameter int ENTRIES = 4,
    parameter int LW      = 12,
    parameter int EIW     = 2
) (
    input  logic [ENTRIES-1:0]         vld,
    input  logic [ENTRIES-1:0][LW-1:0] lines,
    input  logic [LW-1:0]              key,
    output logic                       hit,
    output logic [EIW-1:0]             idx
);
    logic [ENTRIES-1:0] eq;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign eq[e] = vld[e] && (lines[e] == key);
    end

    always_comb begin
        hit = |eq;
        idx = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (eq[e]) idx = EIW'(e);
        end
    end
endmodule

// File: rtl/lrt_age_watch.sv
module lrt_age_watch #(
    parameter int SLOTS  = 16,
    parameter int TW     = 20,
    parameter int THRESH = 500000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [TW-1:0]            now,
    input  logic [SLOTS-1:0][TW-1:0] stamp,
    input  logic [SLOTS-1:0]         live,
    output logic                     stuck
);
    logic [SLOTS-1:0] over;

    for (genvar s = 0; s < SLOTS; s++) begin : g_age
        logic [TW-1:0] age;
        assign age     = now - stamp[s];
        assign over[s] = live[s] && (age >= TW'(THRESH));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     stuck <= 1'b0;
        else if (|over) stuck <= 1'b1;
    end
endmodule

// File: rtl/lrt_table.sv
module lrt_table import lrt_pkg::*; #(
    parameter int AW         = 16,
    parameter int LINE_BYTES = 16,
    parameter int ENTRIES    = 4,
    parameter int QDEPTH     = 4,
    parameter int IDW        = 4,
    parameter int THRESH     = 500000,
    parameter int OFFW       = $clog2(LINE_BYTES),
    parameter int LW         = AW - OFFW,
    parameter int CW         = $clog2(ENTRIES * QDEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           merge_en,
    input  logic           req_valid,
    input  logic [AW-1:0]  req_addr,
    input  logic [3:0]     req_prim,
    input  logic [3:0]     req_sec,
    input  logic [IDW-1:0] req_id,
    output logic [1:0]     rsp_status,
    output logic           iss_valid,
    output logic [LW-1:0]  iss_line,
    output logic [3:0]     iss_kind,
    input  logic           cmp_valid,
    input  logic           cmp_write,
    input  logic [LW-1:0]  cmp_line,
    output logic           done_valid,
    output logic [IDW-1:0] done_id,
    output logic [3:0]     done_kind,
    output logic           done_first,
    input  logic           perm_lost,
    input  logic [LW-1:0]  perm_line,
    output logic           lock_clear,
    output logic           blk_active,
    output logic [LW-1:0]  blk_line,
    output logic [CW-1:0]  pending,
    output logic           deadlock
);
    localparam int EIW   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int QIW   = $clog2(QDEPTH);
    localparam int QCW   = $clog2(QDEPTH + 1);
    localparam int TW    = $clog2(THRESH + 1) + 1;
    localparam int SLOTS = ENTRIES * QDEPTH;

    // Table state
    logic [ENTRIES-1:0]                      ent_vld;
    logic [ENTRIES-1:0][LW-1:0]              ent_line;
    logic [ENTRIES-1:0][QCW-1:0]             q_cnt;
    logic [ENTRIES-1:0][QDEPTH-1:0][IDW-1:0] s_id;
    logic [ENTRIES-1:0][QDEPTH-1:0][3:0]     s_prim;
    logic [ENTRIES-1:0][QDEPTH-1:0][3:0]     s_sec;
    logic [ENTRIES-1:0][QDEPTH-1:0][TW-1:0]  s_stamp;
    logic [SLOTS-1:0]                        live;
    logic [TW-1:0]                           now;

    fsm_e           state, nxt;
    logic [EIW-1:0] d_ent;
    logic           d_first;

    logic [LW-1:0]  req_line;
    logic           r_hit, c_hit, p_hit, f_any, sc_hit;
    logic [EIW-1:0] r_idx, c_idx, p_idx, f_idx;
    logic           do_alloc, do_append, do_pop, do_free, start_drain;
    logic [3:0]     hd_prim;
    logic [QCW-1:0] hd_cnt;
    logic [QIW-1:0] tail;

    assign req_line = req_addr[AW-1:OFFW];
    assign hd_prim  = s_prim[d_ent][0];
    assign hd_cnt   = q_cnt[d_ent];
    assign tail     = q_cnt[r_idx][QIW-1:0];

    lrt_line_match #(.ENTRIES(ENTRIES), .LW(LW), .EIW(EIW)) u_req_match (
        .vld(ent_vld), .lines(ent_line), .key(req_line), .hit(r_hit), .idx(r_idx));
    lrt_line_match #(.ENTRIES(ENTRIES), .LW(LW), .EIW(EIW)) u_cmp_match (
        .vld(ent_vld), .lines(ent_line), .key(cmp_line), .hit(c_hit), .idx(c_idx));
    lrt_line_match #(.ENTRIES(ENTRIES), .LW(LW), .EIW(EIW)) u_perm_match (
        .vld(ent_vld), .lines(ent_line), .key(perm_line), .hit(p_hit), .idx(p_idx));

    for (genvar e = 0; e < ENTRIES; e++) begin : g_live_e
        for (genvar k = 0; k < QDEPTH; k++) begin : g_live_k
            assign live[e*QDEPTH+k] = ent_vld[e] && (q_cnt[e] > QCW'(k));
        end
    end

    lrt_age_watch #(.SLOTS(SLOTS), .TW(TW), .THRESH(THRESH)) u_watch (
        .clk(clk), .rst_n(rst_n), .now(now), .stamp(s_stamp), .live(live), .stuck(deadlock));

    // Lowest free entry
    always_comb begin
        f_any = 1'b0;
        f_idx = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (!ent_vld[e]) begin
                f_any = 1'b1;
                f_idx = EIW'(e);
            end
        end
    end

    // Store-conditional present in the queue of the line losing permission
    always_comb begin
        sc_hit = 1'b0;
        for (int k = 0; k < QDEPTH; k++) begin
            if ((QCW'(k) < q_cnt[p_idx]) && (s_prim[p_idx][k] == K_SC)) sc_hit = 1'b1;
        end
    end
    assign lock_clear = perm_lost && p_hit && sc_hit;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next state and outputs
    always_comb begin
        nxt         = state;
        rsp_status  = RS_NONE;
        iss_valid   = 1'b0;
        iss_line    = req_line;
        iss_kind    = req_sec;
        done_valid  = 1'b0;
        done_id     = s_id[d_ent][0];
        done_kind   = hd_prim;
        done_first  = d_first;
        do_alloc    = 1'b0;
        do_append   = 1'b0;
        do_pop      = 1'b0;
        do_free     = 1'b0;
        start_drain = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (cmp_valid) begin
                        rsp_status = RS_STALL;
                    end else if (r_hit) begin
                        if (!merge_en) begin
                            rsp_status = RS_ALIASED;
                        end else if (q_cnt[r_idx] == QCW'(QDEPTH)) begin
                            rsp_status = RS_STALL;
                        end else begin
                            rsp_status = RS_ISSUED;
                            do_append  = 1'b1;
                        end
                    end else if (!f_any) begin
                        rsp_status = RS_STALL;
                    end else begin
                        rsp_status = RS_ISSUED;
                        do_alloc   = 1'b1;
                        iss_valid  = 1'b1;
                    end
                end
                if (cmp_valid && c_hit) begin
                    start_drain = 1'b1;
                    nxt = cmp_write ? ST_DRAIN_WR : ST_DRAIN_RD;
                end
            end
            ST_DRAIN_RD, ST_DRAIN_WR: begin
                if (req_valid) rsp_status = RS_STALL;
                if ((state == ST_DRAIN_RD) && !d_first && is_wr(hd_prim)) begin
                    iss_valid = 1'b1;
                    iss_line  = ent_line[d_ent];
                    iss_kind  = s_sec[d_ent][0];
                    nxt       = ST_IDLE;
                end else begin
                    do_pop     = 1'b1;
                    done_valid = 1'b1;
                    if (!merge_en || (hd_cnt == QCW'(1))) begin
                        do_free = 1'b1;
                        nxt     = ST_IDLE;
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Control state of the table
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_vld    <= '0;
            q_cnt      <= '0;
            pending    <= '0;
            blk_active <= 1'b0;
            blk_line   <= '0;
            now        <= '0;
            d_ent      <= '0;
            d_first    <= 1'b0;
        end else begin
            now <= now + 1'b1;
            if (do_alloc) begin
                ent_vld[f_idx] <= 1'b1;
                q_cnt[f_idx]   <= QCW'(1);
            end
            if (do_append) q_cnt[r_idx] <= q_cnt[r_idx] + 1'b1;
            if (start_drain) begin
                d_ent   <= c_idx;
                d_first <= 1'b1;
            end
            if (do_pop) begin
                q_cnt[d_ent] <= q_cnt[d_ent] - 1'b1;
                d_first      <= 1'b0;
                if (hd_prim == K_LRMW_RD) begin
                    blk_active <= 1'b1;
                    blk_line   <= ent_line[d_ent];
                end else if (hd_prim == K_LRMW_WR) begin
                    blk_active <= 1'b0;
                end
            end
            if (do_free) begin
                ent_vld[d_ent] <= 1'b0;
                q_cnt[d_ent]   <= '0;
            end
            if ((do_alloc || do_append) && !do_pop)      pending <= pending + 1'b1;
            else if (do_pop && !(do_alloc || do_append)) pending <= pending - 1'b1;
        end
    end

    // Queue contents (no reset needed: qualified by counts)
    always_ff @(posedge clk) begin
        if (do_alloc) begin
            ent_line[f_idx]   <= req_line;
            s_id[f_idx][0]    <= req_id;
            s_prim[f_idx][0]  <= req_prim;
            s_sec[f_idx][0]   <= req_sec;
            s_stamp[f_idx][0] <= now;
        end
        if (do_append) begin
            s_id[r_idx][tail]    <= req_id;
            s_prim[r_idx][tail]  <= req_prim;
            s_sec[r_idx][tail]   <= req_sec;
            s_stamp[r_idx][tail] <= now;
        end
        if (do_pop) begin
            for (int k = 0; k < QDEPTH - 1; k++) begin
                s_id[d_ent][k]    <= s_id[d_ent][k+1];
                s_prim[d_ent][k]  <= s_prim[d_ent][k+1];
                s_sec[d_ent][k]   <= s_sec[d_ent][k+1];
                s_stamp[d_ent][k] <= s_stamp[d_ent][k+1];
            end
        end
    end
endmodule

// File: rtl/lrt_table_chk.sv
module lrt_table_chk import lrt_pkg::*; #(
    parameter int ENTRIES = 4,
    parameter int QDEPTH  = 4,
    parameter int CW      = 5,
    parameter int QCW     = 3
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [1:0]                   rsp_status,
    input logic                         iss_valid,
    input logic                         done_valid,
    input logic [3:0]                   done_kind,
    input logic                         blk_active,
    input logic                         deadlock,
    input logic [CW-1:0]                pending,
    input logic [ENTRIES-1:0][QCW-1:0]  q_cnt
);
    logic [CW-1:0] total;

    always_comb begin
        total = '0;
        for (int e = 0; e < ENTRIES; e++) total = total + CW'(q_cnt[e]);
    end

    AST_ISSUED_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_status == RS_ISSUED |=> pending == $past(pending) + CW'(1)); // R3
    AST_ALIAS_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_status == RS_ALIASED |=> $stable(pending)); // R4
    AST_STALL_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_status == RS_STALL) && !done_valid |=> $stable(pending)); // R5
    AST_DONE_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> pending == $past(pending) - CW'(1)); // R6
    AST_REISSUE_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(iss_valid && done_valid)); // R7
    AST_LOCK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid && (done_kind == K_LRMW_RD) |=> blk_active); // R9
    AST_LOCK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid && (done_kind == K_LRMW_WR) |=> !blk_active); // R9
    AST_DEADLOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        deadlock |=> deadlock); // R11
    AST_COUNT_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        pending == total); // R12
endmodule

bind lrt_table lrt_table_chk #(
    .ENTRIES(ENTRIES), .QDEPTH(QDEPTH), .CW(CW), .QCW(QCW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rsp_status(rsp_status), .iss_valid(iss_valid),
    .done_valid(done_valid), .done_kind(done_kind), .blk_active(blk_active),
    .deadlock(deadlock), .pending(pending), .q_cnt(q_cnt)
);

// File: tb/lrt_table_test.sv
`timescale 1ns/1ps
module lrt_table_test;
    localparam int TH = 200;
    localparam int NE = 4;
    localparam int QD = 4;

    logic        clk = 0, rst_n = 0, merge_en = 1;
    logic        req_valid = 0;
    logic [15:0] req_addr = 0;
    logic [3:0]  req_prim = 0, req_sec = 0;
    logic [3:0]  req_id = 0;
    logic [1:0]  rsp_status;
    logic        iss_valid;
    logic [11:0] iss_line;
    logic [3:0]  iss_kind;
    logic        cmp_valid = 0, cmp_write = 0;
    logic [11:0] cmp_line = 0;
    logic        done_valid;
    logic [3:0]  done_id, done_kind;
    logic        done_first;
    logic        perm_lost = 0;
    logic [11:0] perm_line = 0;
    logic        lock_clear, blk_active;
    logic [11:0] blk_line;
    logic [4:0]  pending;
    logic        deadlock;

    always #2.5 clk = ~clk;

    lrt_table #(.THRESH(TH)) uut (
        .clk(clk), .rst_n(rst_n), .merge_en(merge_en),
        .req_valid(req_valid), .req_addr(req_addr), .req_prim(req_prim),
        .req_sec(req_sec), .req_id(req_id), .rsp_status(rsp_status),
        .iss_valid(iss_valid), .iss_line(iss_line), .iss_kind(iss_kind),
        .cmp_valid(cmp_valid), .cmp_write(cmp_write), .cmp_line(cmp_line),
        .done_valid(done_valid), .done_id(done_id), .done_kind(done_kind),
        .done_first(done_first), .perm_lost(perm_lost), .perm_line(perm_line),
        .lock_clear(lock_clear), .blk_active(blk_active), .blk_line(blk_line),
        .pending(pending), .deadlock(deadlock));

    int checks = 0, errors = 0;

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Behavioural reference: one flat list of queued requests in arrival order
    typedef struct { int line; int id; int prim; int sec; int t; } rec_t;
    rec_t q[$];
    int mode = 0, dline = 0, dfirst = 0, blk = 0, blkl = 0, dl = 0, cyc = 0;

    function automatic int cnt_of(int l);
        int n = 0;
        foreach (q[i]) if (q[i].line == l) n++;
        return n;
    endfunction
    function automatic int nlines();
        int n = 0;
        foreach (q[i]) begin
            bit seen = 0;
            for (int j = 0; j < i; j++) if (q[j].line == q[i].line) seen = 1;
            if (!seen) n++;
        end
        return n;
    endfunction
    function automatic int head_of(int l);
        for (int i = 0; i < q.size(); i++) if (q[i].line == l) return i;
        return -1;
    endfunction
    function automatic int sc_on(int l);
        foreach (q[i]) if (q[i].line == l && q[i].prim == 7) return 1;
        return 0;
    endfunction
    function automatic int iswr(int k);
        return (k != 0 && k != 1) ? 1 : 0;
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            q.delete(); mode = 0; blk = 0; blkl = 0; dl = 0; cyc = 0; dfirst = 0;
        end else begin
            int rl, e_st, e_iv, e_il, e_ik, e_dv, e_did, e_dk, e_df, push, pop_i, nm, ndl;
            string ts, ti, td;
            rl = int'(req_addr) >> 4;
            e_st = 0; e_iv = 0; e_il = 0; e_ik = 0; e_dv = 0; e_did = 0; e_dk = 0; e_df = 0;
            push = 0; pop_i = -1; nm = mode; ndl = 0;
            ts = "R5"; ti = "R2"; td = "R6";
            if (mode == 0) begin
                if (req_valid) begin
                    if (cmp_valid) e_st = 3;
                    else if (cnt_of(rl) > 0) begin
                        if (!merge_en) begin e_st = 2; ts = (req_addr[3:0] != 0) ? "R1" : "R4"; end
                        else if (cnt_of(rl) == QD) e_st = 3;
                        else begin e_st = 1; push = 1; ts = (req_addr[3:0] != 0) ? "R1" : "R3"; end
                    end else if (nlines() == NE) e_st = 3;
                    else begin
                        e_st = 1; push = 1; ts = "R2";
                        e_iv = 1; e_il = rl; e_ik = int'(req_sec);
                    end
                end
                if (cmp_valid && cnt_of(int'(cmp_line)) > 0) begin
                    nm = cmp_write ? 2 : 1; ndl = int'(cmp_line);
                end
            end else begin
                int hi;
                if (req_valid) e_st = 3;
                hi = head_of(dline);
                if (mode == 1 && !dfirst && iswr(q[hi].prim)) begin
                    e_iv = 1; e_il = dline; e_ik = q[hi].sec; ti = "R7"; nm = 0;
                end else begin
                    e_dv = 1; e_did = q[hi].id; e_dk = q[hi].prim; e_df = dfirst; pop_i = hi;
                    td = !merge_en ? "R8" : (mode == 2 ? "R6" : "R7");
                end
            end
            chk(ts, "rsp_status", int'(rsp_status), e_st);
            chk(ti, "iss_valid", int'(iss_valid), e_iv);
            if (e_iv) begin
                chk(ti, "iss_line", int'(iss_line), e_il);
                chk(ti, "iss_kind", int'(iss_kind), e_ik);
            end
            chk(td, "done_valid", int'(done_valid), e_dv);
            if (e_dv) begin
                chk(td, "done_id", int'(done_id), e_did);
                chk(td, "done_kind", int'(done_kind), e_dk);
                chk(td, "done_first", int'(done_first), e_df);
            end
            chk("R10", "lock_clear", int'(lock_clear), (perm_lost && sc_on(int'(perm_line))) ? 1 : 0);
            chk("R12", "pending", int'(pending), q.size());
            chk("R9", "blk_active", int'(blk_active), blk);
            if (blk) chk("R9", "blk_line", int'(blk_line), blkl);
            chk("R11", "deadlock", int'(deadlock), dl);
            foreach (q[i]) if (cyc - q[i].t >= TH) dl = 1;
            if (pop_i >= 0) begin
                if (q[pop_i].prim == 8) begin blk = 1; blkl = dline; end
                else if (q[pop_i].prim == 9) blk = 0;
                q.delete(pop_i);
                dfirst = 0;
                if (!merge_en || cnt_of(dline) == 0) nm = 0;
            end
            if (push) q.push_back('{rl, int'(req_id), int'(req_prim), int'(req_sec), cyc});
            if (mode == 0 && nm != 0) begin dline = ndl; dfirst = 1; end
            mode = nm;
            cyc++;
        end
    end

    task automatic step(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask
    task automatic req(int a, int p, int s, int id);
        req_valid = 1; req_addr = 16'(a); req_prim = 4'(p); req_sec = 4'(s); req_id = 4'(id);
        step(1);
        req_valid = 0;
    endtask
    task automatic cmp(int w, int l);
        cmp_valid = 1; cmp_write = w[0]; cmp_line = 12'(l);
        step(1);
        cmp_valid = 0;
        step(QD + 2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1;
        step(2);
        // R2/R1/R3/R7/R6: loads, then a store, then a load on one line
        req('h120, 0, 0, 1);
        req('h128, 2, 5, 2);
        req('h12C, 0, 1, 3);
        req('h124, 1, 1, 4);
        cmp(0, 'h12);   // pops only id 1, reissues the store with kind 5
        cmp(1, 'h12);   // drains store, load, ifetch
        // Load, load, store: read drain pops two then reissues
        req('h300, 0, 0, 5);
        req('h304, 0, 0, 6);
        req('h308, 3, 4, 7);
        cmp(0, 'h30);
        cmp(1, 'h30);
        // R5: table full, queue full, completion at the same time
        req('h100, 0, 0, 1);
        req('h200, 0, 1, 2);
        req('h400, 0, 0, 3);
        req('h500, 1, 1, 4);
        req('h600, 0, 0, 5);
        req('h104, 0, 0, 6);
        req('h108, 0, 0, 7);
        req('h10C, 0, 0, 8);
        req('h100, 0, 0, 9);
        req_valid = 1; req_addr = 'h200; req_prim = 0; req_id = 10;
        cmp_valid = 1; cmp_write = 0; cmp_line = 'h10;
        step(1);
        req_valid = 0; cmp_valid = 0;
        req('h700, 0, 0, 11);   // arrives during the drain
        step(QD + 2);
        cmp(0, 'h20);
        cmp(0, 'h40);
        cmp(0, 'h50);
        // R9: locked RMW pair
        req('h800, 8, 8, 12);
        cmp(1, 'h80);
        req('h800, 9, 9, 13);
        cmp(1, 'h80);
        // R10: store-conditional hook
        req('h900, 7, 7, 14);
        perm_lost = 1; perm_line = 'h90; step(1);
        perm_line = 'h91; step(1);
        perm_lost = 0;
        cmp(1, 'h90);
        // R8/R4: merging off
        merge_en = 0;
        req('hA00, 0, 0, 1);
        req('hA04, 2, 2, 2);
        req('hA00, 0, 0, 3);
        cmp(0, 'hA0);
        req('hA00, 2, 2, 4);
        cmp(1, 'hA0);
        merge_en = 1;
        // R11: a request left queued past the threshold
        req('hB00, 0, 0, 5);
        step(TH + 6);
        cmp(0, 'hB0);
        step(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule